// File: doc/BRIEF.md
# Software Watchdog Timer with Two-Key Service

The block counts system clock cycles while enabled. If software does not service it before the selected period runs out, it raises a reset request for one cycle and starts counting again from zero. The period is set through a small control register. A prescale bit and a 2-bit timing field together pick one of eight power-of-two periods. The low group runs from 2^9 to 2^15 cycles and the high group from 2^18 to 2^24 cycles.

Software services the watchdog by writing two key bytes to a service register: first 0x55, then 0xAA. Any number of writes to other addresses may fall between the two keys. A complete key pair clears the count. It also moves the control setting last written into the active period. Until that happens, a new control value only waits as a pending setting.

At reset, the prescale bit takes the value of a mode strap input, and the timing field starts at 00. The parameter `SCALE_SHIFT` divides every period by 2^SCALE_SHIFT so that short simulations are possible. It must not exceed 8.

Top module: `sw_watchdog`

## Requirements
- R1: While `rst` is high, `wd_rst_req` is low. After reset, the timing field is 00 and the prescale bit equals the value `mode_strap` had during reset, so the first period is 2^9 cycles when the strap is 0 and 2^18 cycles when it is 1.
- R2: With the prescale bit at 0, timing codes 00, 01, 10 and 11 give periods of 2^9, 2^11, 2^13 and 2^15 cycles.
- R3: With the prescale bit at 1, timing codes 00, 01, 10 and 11 give periods of 2^18, 2^20, 2^22 and 2^24 cycles.
- R4: When the period runs out, `wd_rst_req` is high for exactly one cycle and the count restarts. Consecutive requests are therefore one period apart.
- R5: A write of 0x55 followed later by a write of 0xAA, both to the service address (`wr_addr` = 1), restarts the count. The next request comes one full period after the cycle of the 0xAA write.
- R6: A write of 0xAA to the service address that is not preceded by an armed 0x55 has no effect on the count.
- R7: A write of any value other than 0x55 to the service address, made after 0x55, cancels the armed key. A later 0xAA then does not service the watchdog.
- R8: Writes to the control address made between the two keys do not cancel the armed key.
- R9: A write to the control address changes only the pending setting. The running period stays the same until the next complete key pair.
- R10: While `wd_enable` is low, the count is held at zero and no request is raised. After the enable returns, the first request comes one full period later.
- R11: The control register sits at `wr_addr` = 0. Bits [1:0] of the written byte are the timing field and bit 2 is the prescale bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | Mode strap, sampled while in reset to set the prescale bit |
| wd_enable | input | 1 | Enables counting when high |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 1 | Register select: 0 is control, 1 is service |
| wr_data | input | 8 | Write data byte |
| wd_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The assertions assume one bus write per cycle at most, a strap that is stable while reset is held, and a scale shift that leaves every period at least two cycles long. The stimulus keeps to these limits. It changes inputs only on the falling edge and issues writes one per cycle. It uses a scale shift of 8, so the shortest period is two cycles and the longest is 65536 cycles, and it re-enters reset only with the strap already settled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned ADDR_W  = 1;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned EXP_W   = 5;
    localparam int unsigned MAX_EXP = 24;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_SVC  = 1'b1;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

    typedef struct packed {
        logic       presc;
        logic [1:0] sel;
    } wd_cfg_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    // log2 of the unscaled time-out ratio
    function automatic logic [EXP_W-1:0] ratio_exp(wd_cfg_t c);
        logic [EXP_W-1:0] step;
        step = {2'b00, c.sel, 1'b0};
        return c.presc ? (5'd18 + step) : (5'd9 + step);
    endfunction

    function automatic wd_cfg_t cfg_from_byte(logic [DATA_W-1:0] b);
        wd_cfg_t c;
        c.presc = b[2];
        c.sel   = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              svc_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              svc_o
);

    seq_state_t state_q;
    logic       svc_wr;

    assign svc_wr = wr_en && svc_sel;
    assign svc_o  = svc_wr && (wr_data == KEY_FIRE) && (state_q == SEQ_ARMED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else if (svc_wr) begin
            state_q <= (wr_data == KEY_ARM) ? SEQ_ARMED : SEQ_IDLE;
        end
    end

    AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && wr_data != KEY_ARM) |=> (state_q == SEQ_IDLE)); // R7

    AST_CTRL_KEEPS_ARM: assert property (@(posedge clk) disable iff (rst)
        (!svc_wr) |=> $stable(state_q)); // R8

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strap,
    input  logic    cfg_we,
    input  wd_cfg_t cfg_in,
    input  logic    svc,
    output wd_cfg_t active_o
);

    wd_cfg_t pending_q;
    wd_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q.presc <= strap;
            pending_q.sel   <= 2'b00;
        end else if (cfg_we) begin
            pending_q <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q.presc <= strap;
            active_q.sel   <= 2'b00;
        end else if (svc) begin
            active_q <= pending_q;
        end
    end

    assign active_o = active_q;

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!svc) |=> $stable(active_o)); // R9

    AST_ACTIVE_LOADS: assert property (@(posedge clk) disable iff (rst)
        svc |=> (active_o == $past(pending_q))); // R9

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    svc,
    input  wd_cfg_t active,
    output logic    req_o
);

    localparam int unsigned CNT_W = MAX_EXP - SCALE_SHIFT;

    logic [EXP_W-1:0] eff_exp;
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign eff_exp = ratio_exp(active) - EXP_W'(SCALE_SHIFT);
    assign ratio   = (CNT_W+1)'(1) << eff_exp;
    assign last    = CNT_W'(ratio - (CNT_W+1)'(1));
    assign at_end  = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_o <= 1'b0;
        end else begin
            req_o <= en && !svc && at_end;
            if (!en || svc || at_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last); // R4

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (cnt_q == '0 && !req_o)); // R10

    AST_SVC_RESTART: assert property (@(posedge clk) disable iff (rst)
        svc |=> (cnt_q == '0 && !req_o)); // R5

endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_strap,
    input  logic              wd_enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wd_rst_req
);

    logic    svc_sel;
    logic    cfg_we;
    logic    svc;
    wd_cfg_t cfg_in;
    wd_cfg_t active;

    assign svc_sel = (wr_addr == ADDR_SVC);
    assign cfg_we  = wr_en && (wr_addr == ADDR_CTRL);
    assign cfg_in  = cfg_from_byte(wr_data);

    wdog_keyseq u_keyseq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .svc_sel (svc_sel),
        .wr_data (wr_data),
        .svc_o   (svc)
    );

    wdog_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .strap    (mode_strap),
        .cfg_we   (cfg_we),
        .cfg_in   (cfg_in),
        .svc      (svc),
        .active_o (active)
    );

    wdog_counter #(
        .SCALE_SHIFT (SCALE_SHIFT)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .en     (wd_enable),
        .svc    (svc),
        .active (active),
        .req_o  (wd_rst_req)
    );

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |=> !wd_rst_req); // R1

endmodule

// File: tb/sw_watchdog_bench.sv
module sw_watchdog_bench;

    localparam int SH = 8;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_strap = 1'b0;
    logic       wd_enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wd_rst_req;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string cur_req = "R1";
    bit    done   = 1'b0;

    // reference model state
    int m_cnt = 0;
    bit m_arm = 0;
    bit m_pp = 0;
    int m_ps = 0;
    bit m_ap = 0;
    int m_as = 0;
    bit m_req = 0;

    always #2 clk = ~clk;

    sw_watchdog #(.SCALE_SHIFT(SH)) u_sw_watchdog (
        .clk        (clk),
        .rst        (rst),
        .mode_strap (mode_strap),
        .wd_enable  (wd_enable),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wd_rst_req (wd_rst_req)
    );

    function automatic int period(bit p, int s);
        int e;
        e = p ? (18 + 2 * s) : (9 + 2 * s);
        return 1 << (e - SH);
    endfunction

    always @(posedge clk) begin
        bit svc;
        int lim;
        cyc = cyc + 1;
        if (rst) begin
            m_cnt = 0; m_arm = 0; m_pp = mode_strap; m_ps = 0;
            m_ap = mode_strap; m_as = 0; m_req = 0;
        end else begin
            svc = wr_en && wr_addr == 1'b1 && wr_data == 8'hAA && m_arm;
            lim = period(m_ap, m_as);
            m_req = wd_enable && !svc && (m_cnt == lim - 1);
            if (!wd_enable || svc || m_cnt == lim - 1) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (wr_en && wr_addr == 1'b1) m_arm = (wr_data == 8'h55);
            if (wr_en && wr_addr == 1'b0) begin
                m_pp = wr_data[2];
                m_ps = int'(wr_data[1:0]);
            end
            if (svc) begin
                m_ap = m_pp;
                m_as = m_ps;
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) check(cur_req, int'(wd_rst_req), int'(m_req), "model compare");
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > WD_LIMIT && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic wr(bit a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic service();
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
    endtask

    task automatic wait_pulse();
        while (!wd_rst_req) @(negedge clk);
    endtask

    // checks that the next request arrives lim cycles after cycle t0 and lasts one cycle
    task automatic expect_pulse(string req, int t0, int lim);
        wait_pulse();
        check(req, cyc - t0, lim, "cycles to request");
        @(negedge clk);
        check("R4", int'(wd_rst_req), 0, "request width");
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst = 1'b1; mode_strap = strap; wd_enable = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1", int'(wd_rst_req), 0, "request in reset");
        end
        rst = 1'b0; wd_enable = 1'b1;
    endtask

    initial begin
        int t0;
        // R1 reset with strap 0
        cur_req = "R1";
        do_reset(1'b0);
        t0 = cyc;
        expect_pulse("R1", t0, period(0, 0));
        t0 = cyc;
        expect_pulse("R4", t0 - 1, period(0, 0));

        // R2, R11: low group
        for (int s = 1; s < 4; s++) begin
            cur_req = "R2";
            wr(1'b0, 8'(s));
            service();
            t0 = cyc;
            expect_pulse("R2", t0, period(0, s));
            t0 = cyc - 1;
            expect_pulse("R11", t0, period(0, s));
        end

        // R9: pending setting does not change running period
        cur_req = "R9";
        wr(1'b0, 8'h00);
        service();
        wait_pulse();
        t0 = cyc;
        wr(1'b0, 8'h02);
        expect_pulse("R9", t0, period(0, 0));
        service();
        t0 = cyc;
        expect_pulse("R9", t0, period(0, 2));

        // R6: lone second key ignored
        cur_req = "R6";
        wr(1'b0, 8'h03);
        service();
        t0 = cyc;
        repeat (40) @(negedge clk);
        wr(1'b1, 8'hAA);
        expect_pulse("R6", t0, period(0, 3));

        // R7: other value cancels the armed key
        cur_req = "R7";
        service();
        t0 = cyc;
        repeat (20) @(negedge clk);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h12);
        wr(1'b1, 8'hAA);
        expect_pulse("R7", t0, period(0, 3));

        // R8: control write between keys keeps the key armed
        cur_req = "R8";
        repeat (10) @(negedge clk);
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h03);
        repeat (5) @(negedge clk);
        wr(1'b1, 8'hAA);
        t0 = cyc;
        expect_pulse("R8", t0, period(0, 3));

        // R5: repeated service holds off the request
        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            repeat (60) @(negedge clk);
            service();
        end
        t0 = cyc;
        expect_pulse("R5", t0, period(0, 3));

        // R10: disabled watchdog stays quiet
        cur_req = "R10";
        wd_enable = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (wd_rst_req) seen++;
            end
            check("R10", seen, 0, "requests while disabled");
        end
        t0 = cyc;
        wd_enable = 1'b1;
        expect_pulse("R10", t0, period(0, 3));

        // R1 with strap 1: high group default
        cur_req = "R1";
        do_reset(1'b1);
        t0 = cyc;
        expect_pulse("R1", t0, period(1, 0));

        // R3: high group
        for (int s = 1; s < 4; s++) begin
            cur_req = "R3";
            wr(1'b0, 8'(4 + s));
            service();
            t0 = cyc;
            expect_pulse("R3", t0, period(1, s));
        end

        finish_run();
    end

endmodule